// File: doc/BRIEF.md
# Power-of-Two Card Clock Divider

This block derives the bus clock for a memory-card host from the peripheral clock. A 4-bit select code picks a division ratio from the powers of two between 2 and 512. A software clock-enable bit decides whether the card clock runs at all. A static strap input states whether the host may pass the undivided peripheral clock straight through to the card.

A card is typically brought up slowly, at /256 during identification, and is then moved to /4 for data transfer. Such a change, and any change of the enable, takes effect only on a falling edge of the card clock, so the card never sees a shortened pulse. Codes that name no valid ratio fall back to the slowest ratio. The card can therefore never be clocked faster than the host intended.

Top module: `card_clk_div`

## Requirements
- R1: A select code n in 0..8 divides the peripheral clock by 2^(n+1) with 50% duty: the card clock is high for 2^n peripheral cycles and low for 2^n peripheral cycles.
- R2: Select codes 9 to 14, and code 15 while the pass-through strap is 0, divide by 512 (high 256 cycles, low 256 cycles).
- R3: While the enable input is 0, and the block has settled, the card clock stays low and the running flag is 0.
- R4: Code 15 with the pass-through strap at 1 drives the card clock as a copy of the peripheral clock. On leaving pass-through, the first divided period that follows has its full length.
- R5: A select change made during a high phase does not shorten that phase. The new ratio starts at the falling edge that ends it, with a full low half-period of the new ratio.
- R6: Clearing the enable during a high phase lets that phase finish at full length. The running flag drops at the falling edge that ends it, and the clock then stays low.
- R7: From the stopped state, the running flag rises on the first clock edge after the enable is seen. The first rising edge of the card clock follows 2^n cycles after that.
- R8: The active-low asynchronous reset drives the card clock low and the running flag to 0 at once, and clears the internal counter. The first period after reset therefore starts in phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 4 | Division select code |
| clk_en_i | input | 1 | Card clock enable |
| pass_ok_i | input | 1 | Strap: undivided pass-through allowed |
| card_clk_o | output | 1 | Card bus clock |
| running_o | output | 1 | Card clock is active |

## Verification
A wrong tap decode or a stale counter shows up directly in the high and low run lengths of the card clock. The first period after a setting is loaded already has the wrong length, so the bench measures both half-periods of the period that follows every change. A configuration loaded at the wrong moment appears as a high phase shorter than the old ratio, or as a low phase other than the new half-period, within one card clock period. A missing fallback for an invalid code appears as a period shorter than 512 cycles.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int unsigned SEL_W    = 4;
  localparam int unsigned MAX_LOG2 = 9;                 // slowest ratio 2^MAX_LOG2
  localparam int unsigned SHIFT_W  = $clog2(MAX_LOG2);
  localparam int unsigned CNT_W    = MAX_LOG2 - 1;

  typedef struct packed {
    logic               en;
    logic               byp;
    logic [SHIFT_W-1:0] shift;
  } ckdiv_cfg_t;
endpackage

// File: rtl/ckdiv_decode.sv
module ckdiv_decode
  import ckdiv_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  input  logic             pass_ok_i,
  output ckdiv_cfg_t       cfg_o
);
  always_comb begin
    cfg_o    = '0;
    cfg_o.en = en_i;
    if (sel_i <= SEL_W'(MAX_LOG2 - 1))
      cfg_o.shift = SHIFT_W'(sel_i);
    else if ((&sel_i) && pass_ok_i)
      cfg_o.byp = 1'b1;
    else
      cfg_o.shift = SHIFT_W'(MAX_LOG2 - 1);  // never overclock on bad code
  end
endmodule

// File: rtl/ckdiv_counter.sv
module ckdiv_counter
  import ckdiv_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask[i] = (SHIFT_W'(i) < shift_i);
  end

  assign tick_o = &(cnt_q | ~mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  a_r8_cnt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/ckdiv_gate.sv
module ckdiv_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pass_en_i,
  input  logic div_i,
  output logic card_clk_o
);
  logic gate_q;

  // updated while clk_i is low, so a pass-through pulse is never cut
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= pass_en_i;
  end

  assign card_clk_o = (clk_i & gate_q) | div_i;

  a_r4_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_q |-> !div_i);
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import ckdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic             clk_en_i,
  input  logic             pass_ok_i,
  output logic             card_clk_o,
  output logic             running_o
);
  ckdiv_cfg_t dec_cfg, act_q;
  logic       tick, load, div_q;

  ckdiv_decode u_decode (
    .sel_i     (div_sel_i),
    .en_i      (clk_en_i),
    .pass_ok_i (pass_ok_i),
    .cfg_o     (dec_cfg)
  );

  // new setting is taken when stopped, in pass-through, or at a falling edge
  assign load = !act_q.en || act_q.byp || (div_q && tick);

  ckdiv_counter u_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .shift_i (act_q.shift),
    .tick_o  (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      div_q <= 1'b0;
    end else if (load) begin
      act_q <= dec_cfg;
      div_q <= 1'b0;
    end else if (tick) begin
      div_q <= 1'b1;
    end
  end

  ckdiv_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pass_en_i  (act_q.en && act_q.byp),
    .div_i      (div_q),
    .card_clk_o (card_clk_o)
  );

  assign running_o = act_q.en;

  a_r3_stopped_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q.en |-> !div_q);
  a_r4_bypass_div_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q.byp |-> !div_q);
  a_r5_switch_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> !div_q);
  a_r2_overrange_slowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_sel_i > SEL_W'(MAX_LOG2 - 1) && !((&div_sel_i) && pass_ok_i))
      |-> (dec_cfg.shift == SHIFT_W'(MAX_LOG2 - 1) && !dec_cfg.byp));
  a_r6_stop_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(act_q.en) |-> (!div_q && ($past(div_q) || $past(act_q.byp))));
endmodule

// File: tb/tb_card_clk_div.sv
module tb_card_clk_div;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] div_sel_i = 4'd0;
  logic       clk_en_i = 1'b0;
  logic       pass_ok_i = 1'b0;
  logic       card_clk_o, running_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  card_clk_div dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_sel_i(div_sel_i), .clk_en_i(clk_en_i),
    .pass_ok_i(pass_ok_i), .card_clk_o(card_clk_o), .running_o(running_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample(output logic v);
    @(negedge clk_i); #1; v = card_clk_o;
  endtask

  task automatic wait_rise();
    logic p, v;
    sample(p);
    for (int i = 0; i < 2000; i++) begin
      sample(v);
      if (!p && v) return;
      p = v;
    end
  endtask

  // called just after a rise was sampled; ends on the next rise
  task automatic measure(output int hi, output int lo);
    logic v;
    hi = 1; lo = 0;
    for (int i = 0; i < 2000; i++) begin
      sample(v); if (!v) break; hi++;
    end
    lo = 1;
    for (int i = 0; i < 2000; i++) begin
      sample(v); if (v) break; lo++;
    end
  endtask

  task automatic settle_code(input logic [3:0] code, input logic pok);
    int h, l;
    div_sel_i = code; pass_ok_i = pok;
    wait_rise();
    measure(h, l);
  endtask

  task automatic t_reset();
    chk("R8 reset clk", card_clk_o, 0);
    chk("R8 reset running", running_o, 0);
  endtask

  task automatic t_disabled();
    logic v; int highs = 0;
    clk_en_i = 1'b0; div_sel_i = 4'd0;
    for (int i = 0; i < 20; i++) begin sample(v); if (v) highs++; end
    chk("R3 disabled highs", highs, 0);
    chk("R3 disabled running", running_o, 0);
  endtask

  task automatic t_start();
    logic v; int lows = 0;
    div_sel_i = 4'd2; @(negedge clk_i); #1; clk_en_i = 1'b1;
    sample(v);
    chk("R7 running after enable", running_o, 1);
    while (!v && lows < 100) begin lows++; sample(v); end
    chk("R7 lows before first rise", lows, 4);
  endtask

  task automatic t_ratio(input string req, input logic [3:0] code, input logic pok,
                         input int half);
    int h, l;
    settle_code(code, pok);
    measure(h, l);
    chk({req, " high"}, h, half);
    chk({req, " low"}, l, half);
  endtask

  task automatic t_switch();
    int h, l;
    settle_code(4'd2, 1'b0);      // now just after a rise at /8
    div_sel_i = 4'd0;
    measure(h, l);
    chk("R5 old high kept", h, 4);
    chk("R5 new low", l, 1);
    measure(h, l);
    chk("R5 new period high", h, 1);
  endtask

  task automatic t_bypass();
    int bad = 0, h, l;
    div_sel_i = 4'd15; pass_ok_i = 1'b1;
    repeat (20) @(posedge clk_i);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk_i); #1; if (card_clk_o !== 1'b1) bad++;
      @(negedge clk_i); #1; if (card_clk_o !== 1'b0) bad++;
    end
    chk("R4 bypass follows clock", bad, 0);
    chk("R4 bypass running", running_o, 1);
    div_sel_i = 4'd1;
    wait_rise();
    measure(h, l);
    chk("R4 after bypass high", h, 2);
    chk("R4 after bypass low", l, 2);
    pass_ok_i = 1'b0;
  endtask

  task automatic t_stop();
    int h = 1, highs = 0; logic v;
    settle_code(4'd2, 1'b0);
    clk_en_i = 1'b0;
    for (int i = 0; i < 100; i++) begin sample(v); if (!v) break; h++; end
    chk("R6 last high full", h, 4);
    chk("R6 running drops at fall", running_o, 0);
    for (int i = 0; i < 20; i++) begin sample(v); if (v) highs++; end
    chk("R6 stays low", highs, 0);
  endtask

  task automatic t_async_reset();
    logic v; int lows = 0;
    div_sel_i = 4'd3; clk_en_i = 1'b1;
    wait_rise();
    rst_ni = 1'b0; #1;
    chk("R8 async clk low", card_clk_o, 0);
    chk("R8 async running low", running_o, 0);
    div_sel_i = 4'd0;
    @(negedge clk_i); #1; rst_ni = 1'b1;
    sample(v);
    while (!v && lows < 100) begin lows++; sample(v); end
    chk("R8 in phase after reset", lows, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1; t_reset();
    rst_ni = 1'b1;
    t_disabled();
    t_start();
    t_ratio("R1 code0", 4'd0, 1'b0, 1);
    t_ratio("R1 code1", 4'd1, 1'b0, 2);
    t_ratio("R1 code3", 4'd3, 1'b0, 8);
    t_ratio("R1 code7 ident", 4'd7, 1'b0, 128);
    t_ratio("R1 code1 data", 4'd1, 1'b0, 2);
    t_ratio("R1 code8", 4'd8, 1'b0, 256);
    t_ratio("R2 code9", 4'd9, 1'b0, 256);
    t_ratio("R2 code14", 4'd14, 1'b1, 256);
    t_ratio("R2 code15 no strap", 4'd15, 1'b0, 256);
    t_switch();
    t_bypass();
    t_stop();
    t_async_reset();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule